// File: doc/BRIEF.md
# CRT Timing Register File with Write Protection

This block holds the byte-wide registers that program a display controller's CRT timing. The host reaches them through I/O ports. It first writes an index to the index port. It then reads or writes the selected register through the data port. The port pair moves between two address pages, 0x3Bx and 0x3Dx. Bit 0 of a miscellaneous output register picks the page, and that register is always reachable at 0x3C2. A port on the page that is not selected is treated as foreign. Reads of a foreign port return all ones, and writes to it change nothing.

A protect flag sits in bit 7 of register 0x11. While it is set, the low timing registers 0 to 7 refuse data writes. Bit 4 of register 7 is the one exception and still takes the written value. Whenever an accepted write touches a register that shapes timing, the block raises a one-cycle update pulse for the timing generator, which lives elsewhere. A write to the miscellaneous output register raises the same pulse. The first 32 registers are exported as a flat bus, together with the miscellaneous and feature control values.

Top module: `crtc_regs`

## Requirements
- R1: After reset, all 256 registers, the index, the miscellaneous value, the feature value, `io_rdata` and `timing_upd` are zero.
- R2: With `misc_value` bit 0 at 1, the index, data and feature ports are 0x3D4, 0x3D5 and 0x3DA. With bit 0 at 0, they are 0x3B4, 0x3B5 and 0x3BA.
- R3: A read of 0x?4, 0x?5 or 0x?A on the page that is not selected returns 0xFF. A write to such a port changes no register, index or feature value, and raises no pulse.
- R4: A write to the index port stores all 8 bits. A read of the index port returns the index. A read of the data port returns the register the index selects. Reads of any other address return 0x00.
- R4 (timing): `io_rdata` takes its new value one cycle after `io_rd` and holds it while `io_rd` is low.
- R5: While the protect flag is clear, a data write stores the full byte in the indexed register.
- R6: While bit 7 of register 0x11 is set, data writes to registers 0 to 6 leave them unchanged. Registers 8 and above are still written.
- R7: While protected, a data write to register 7 replaces only bit 4 and keeps its other bits.
- R8: `timing_upd` is high for exactly the cycle after an accepted data write to register 0x00, 0x04, 0x05, 0x06, 0x07, 0x11 or 0x17. It stays low after a blocked or partial protected write, and after writes to other registers.
- R9: A write to 0x3C2, on either page setting, stores the byte with bit 4 cleared and raises `timing_upd` for one cycle.
- R10: A write to the active feature port stores only bit 4 of the byte and zeroes the other bits.
- R11: `crt_regs[8k+7:8k]` shows register k for k from 0 to 31, updated one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one transfer per high cycle |
| io_wdata | input | 8 | Write byte |
| io_rd | input | 1 | Read strobe, one transfer per high cycle |
| io_rdata | output | 8 | Read byte, registered |
| misc_value | output | 8 | Miscellaneous output register; bit 0 selects the 0x3Dx page |
| feat_value | output | 8 | Feature control register |
| crt_regs | output | 256 | Registers 0 to 31, byte k at bits 8k+7:8k |
| timing_upd | output | 1 | One-cycle timing update pulse |

## Verification
All results are registered, so each one is due one cycle after its strobe. `io_rdata`, the stored registers, the exported bytes and `timing_upd` all show the effect of a transfer right after the next rising edge. If a read and a write fall in the same cycle, the read sees the values from before the write. The bench drives every transfer at a falling edge and samples every output at the following falling edge. Its behavioural model advances by exactly one transfer per cycle, so each comparison falls in the cycle where the result is due.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_INDEX,
    ACC_DATA,
    ACC_FEAT,
    ACC_MISC,
    ACC_REJECT
  } crtc_acc_e;

  // low nibble of each port within its page
  localparam logic [3:0]  OFS_INDEX = 4'h4;
  localparam logic [3:0]  OFS_DATA  = 4'h5;
  localparam logic [3:0]  OFS_FEAT  = 4'hA;
  localparam logic [11:0] MONO_PAGE  = 12'h03B;
  localparam logic [11:0] COLOR_PAGE = 12'h03D;
  localparam logic [15:0] MISC_PORT  = 16'h03C2;

  // bits kept on write
  localparam logic [7:0] MISC_KEEP = 8'hEF;
  localparam logic [7:0] FEAT_KEEP = 8'h10;

  function automatic logic timing_reg(input logic [7:0] i);
    return i inside {8'h00, 8'h04, 8'h05, 8'h06, 8'h07, 8'h11, 8'h17};
  endfunction

endpackage

// File: rtl/crtc_port_decode.sv
module crtc_port_decode
  import crtc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic          color,
  output crtc_acc_e     acc
);
  localparam int PW = AW - 4;
  localparam logic [PW-1:0] MONO_PG  = PW'(MONO_PAGE);
  localparam logic [PW-1:0] COLOR_PG = PW'(COLOR_PAGE);

  logic [PW-1:0] page;
  logic [3:0]    ofs;
  logic          own_page, far_page, crt_ofs;

  always_comb begin
    page     = addr[AW-1:4];
    ofs      = addr[3:0];
    own_page = (page == (color ? COLOR_PG : MONO_PG));
    far_page = (page == (color ? MONO_PG : COLOR_PG));
    crt_ofs  = (ofs == OFS_INDEX) || (ofs == OFS_DATA) || (ofs == OFS_FEAT);
    acc      = ACC_NONE;
    if (addr == AW'(MISC_PORT))             acc = ACC_MISC;
    else if (own_page && ofs == OFS_INDEX)  acc = ACC_INDEX;
    else if (own_page && ofs == OFS_DATA)   acc = ACC_DATA;
    else if (own_page && ofs == OFS_FEAT)   acc = ACC_FEAT;
    else if (far_page && crt_ofs)           acc = ACC_REJECT;
  end

endmodule

// File: rtl/crtc_lock_filter.sv
module crtc_lock_filter
  import crtc_pkg::*;
#(
  parameter int IW         = 8,
  parameter int LOCK_LAST  = 7,
  parameter int EXEMPT_BIT = 4
) (
  input  logic [IW-1:0] idx,
  input  logic          locked,
  output logic [7:0]    wmask,
  output logic          upd_ok
);
  localparam logic [7:0] EXEMPT_MASK = 8'(1 << EXEMPT_BIT);

  logic in_zone;

  always_comb begin
    in_zone = (idx <= IW'(LOCK_LAST));
    if (locked && in_zone) begin
      wmask  = (idx == IW'(LOCK_LAST)) ? EXEMPT_MASK : 8'h00;
      upd_ok = 1'b0;
    end else begin
      wmask  = 8'hFF;
      upd_ok = timing_reg(8'(idx));
    end
  end

endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile #(
  parameter int NREG     = 256,
  parameter int NEXP     = 32,
  parameter int LOCK_REG = 17,
  parameter int LOCK_BIT = 7,
  localparam int IW      = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     widx,
  input  logic [7:0]        wmask,
  input  logic [7:0]        wdata,
  input  logic [IW-1:0]     ridx,
  output logic [7:0]        rdata,
  output logic              locked,
  output logic [NEXP*8-1:0] exp_regs
);
  logic [7:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) mem[k] <= 8'h00;
    end else if (we) begin
      mem[widx] <= (mem[widx] & ~wmask) | (wdata & wmask);
    end
  end

  assign rdata  = mem[ridx];
  assign locked = mem[LOCK_REG][LOCK_BIT];

  for (genvar g = 0; g < NEXP; g++) begin : g_exp
    assign exp_regs[8*g +: 8] = mem[g];
  end

endmodule

// File: rtl/crtc_regs.sv
module crtc_regs
  import crtc_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 256,
  parameter int NEXP = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     io_addr,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  output logic [7:0]        misc_value,
  output logic [7:0]        feat_value,
  output logic [NEXP*8-1:0] crt_regs,
  output logic              timing_upd
);
  localparam int IW = $clog2(NREG);

  crtc_acc_e     acc;
  logic [IW-1:0] idx_q;
  logic [7:0]    misc_q, feat_q, rdata_q, rd_mux;
  logic [7:0]    wmask, rf_rdata;
  logic          upd_q, locked, upd_ok, rf_we;

  crtc_port_decode #(.AW(AW)) u_decode (
    .addr  (io_addr),
    .color (misc_q[0]),
    .acc   (acc)
  );

  crtc_lock_filter #(.IW(IW)) u_lock (
    .idx    (idx_q),
    .locked (locked),
    .wmask  (wmask),
    .upd_ok (upd_ok)
  );

  assign rf_we = io_wr && (acc == ACC_DATA);

  crtc_regfile #(.NREG(NREG), .NEXP(NEXP)) u_file (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (rf_we),
    .widx     (idx_q),
    .wmask    (wmask),
    .wdata    (io_wdata),
    .ridx     (idx_q),
    .rdata    (rf_rdata),
    .locked   (locked),
    .exp_regs (crt_regs)
  );

  always_comb begin
    unique case (acc)
      ACC_INDEX:  rd_mux = 8'(idx_q);
      ACC_DATA:   rd_mux = rf_rdata;
      ACC_REJECT: rd_mux = 8'hFF;
      default:    rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      misc_q  <= 8'h00;
      feat_q  <= 8'h00;
      rdata_q <= 8'h00;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (io_wr) begin
        case (acc)
          ACC_MISC: begin
            misc_q <= io_wdata & MISC_KEEP;
            upd_q  <= 1'b1;
          end
          ACC_INDEX: idx_q  <= io_wdata[IW-1:0];
          ACC_FEAT:  feat_q <= io_wdata & FEAT_KEEP;
          ACC_DATA:  upd_q  <= upd_ok;
          default: ;
        endcase
      end
      if (io_rd) rdata_q <= rd_mux;
    end
  end

  assign io_rdata   = rdata_q;
  assign misc_value = misc_q;
  assign feat_value = feat_q;
  assign timing_upd = upd_q;

endmodule

// File: rtl/crtc_regs_chk.sv
module crtc_regs_chk #(
  parameter int AW   = 16,
  parameter int NEXP = 32,
  parameter int IW   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     io_addr,
  input logic              io_wr,
  input logic [7:0]        io_wdata,
  input logic              io_rd,
  input logic [7:0]        io_rdata,
  input logic [7:0]        misc_value,
  input logic [7:0]        feat_value,
  input logic [NEXP*8-1:0] crt_regs,
  input logic              timing_upd,
  input logic [IW-1:0]     cur_idx
);
  logic [AW-1:0] act_base, far_base;
  logic          far_port, act_data, act_feat, prot;

  always_comb begin
    act_base = misc_value[0] ? AW'(16'h03D0) : AW'(16'h03B0);
    far_base = misc_value[0] ? AW'(16'h03B0) : AW'(16'h03D0);
    far_port = (io_addr == far_base + AW'(4)) || (io_addr == far_base + AW'(5)) ||
               (io_addr == far_base + AW'(10));
    act_data = (io_addr == act_base + AW'(5));
    act_feat = (io_addr == act_base + AW'(10));
    prot     = crt_regs[8*17+7];
  end

  // R8
  upd_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timing_upd |-> $past(io_wr));

  // R3
  far_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && far_port) |=> (io_rdata == 8'hFF));

  // R9
  misc_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == AW'(16'h03C2)) |=>
      ((misc_value == ($past(io_wdata) & 8'hEF)) && timing_upd));

  // R10
  feat_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && act_feat) |=> (feat_value == ($past(io_wdata) & 8'h10)));

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && act_data && prot && cur_idx < IW'(7)) |=> $stable(crt_regs[63:0]));

  // R7
  exempt_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && act_data && prot && cur_idx == IW'(7)) |=>
      ((crt_regs[60] == $past(io_wdata[4])) &&
       (crt_regs[59:56] == $past(crt_regs[59:56])) &&
       (crt_regs[63:61] == $past(crt_regs[63:61]))));

endmodule

bind crtc_regs crtc_regs_chk #(.AW(AW), .NEXP(NEXP), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_addr    (io_addr),
  .io_wr      (io_wr),
  .io_wdata   (io_wdata),
  .io_rd      (io_rd),
  .io_rdata   (io_rdata),
  .misc_value (misc_value),
  .feat_value (feat_value),
  .crt_regs   (crt_regs),
  .timing_upd (timing_upd),
  .cur_idx    (idx_q)
);

// File: tb/test_crtc_regs.sv
module test_crtc_regs;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  io_addr = 16'h0;
  logic         io_wr = 1'b0;
  logic [7:0]   io_wdata = 8'h0;
  logic         io_rd = 1'b0;
  logic [7:0]   io_rdata, misc_value, feat_value;
  logic [255:0] crt_regs;
  logic         timing_upd;

  int checks = 0;
  int errors = 0;

  // reference state
  int m_reg [256];
  int m_idx, m_misc, m_feat, m_rdata, m_upd;

  always #4 clk = ~clk;

  crtc_regs i_crtc_regs (
    .clk, .rst_n, .io_addr, .io_wr, .io_wdata, .io_rd,
    .io_rdata, .misc_value, .feat_value, .crt_regs, .timing_upd
  );

  task automatic chk(input string tag, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [255:0] ev;
    for (int k = 0; k < 32; k++) ev[8*k +: 8] = 8'(m_reg[k]);
    chk(tag, "rdata", 256'(io_rdata), 256'(m_rdata));
    chk(tag, "misc", 256'(misc_value), 256'(m_misc));
    chk(tag, "feat", 256'(feat_value), 256'(m_feat));
    chk(tag, "upd", 256'(timing_upd), 256'(m_upd));
    chk(tag, "regs", crt_regs, ev);
  endtask

  task automatic model(input bit wr, input bit rd, input int a, input int d);
    int act, far, lo;
    act = m_misc[0] ? 'h3D0 : 'h3B0;
    far = m_misc[0] ? 'h3B0 : 'h3D0;
    m_upd = 0;
    if (rd) begin
      if (a == act + 4)      m_rdata = m_idx;
      else if (a == act + 5) m_rdata = m_reg[m_idx];
      else if (a == far + 4 || a == far + 5 || a == far + 10) m_rdata = 'hFF;
      else                   m_rdata = 0;
    end
    if (wr) begin
      if (a == 'h3C2) begin
        m_misc = d & 'hEF; m_upd = 1;
      end else if (a == act + 4) m_idx = d;
      else if (a == act + 10)    m_feat = d & 'h10;
      else if (a == act + 5) begin
        lo = (m_reg['h11] & 'h80) != 0;
        if (lo && m_idx <= 7) begin
          if (m_idx == 7) m_reg[7] = (m_reg[7] & 'hEF) | (d & 'h10);
        end else begin
          m_reg[m_idx] = d;
          if (m_idx == 0 || m_idx == 4 || m_idx == 5 || m_idx == 6 ||
              m_idx == 7 || m_idx == 'h11 || m_idx == 'h17) m_upd = 1;
        end
      end
    end
  endtask

  task automatic step(input bit wr, input bit rd, input logic [15:0] a,
                      input logic [7:0] d, input string tag);
    io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d;
    model(wr, rd, int'(a), int'(d));
    @(posedge clk);
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    compare(tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    step(1'b1, 1'b0, a, d, tag);
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    step(1'b0, 1'b1, a, 8'h00, tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL R1 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) m_reg[k] = 0;
    m_idx = 0; m_misc = 0; m_feat = 0; m_rdata = 0; m_upd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    // mono page active
    wr(16'h03B4, 8'h11, "R2");
    rd(16'h03B4, "R4");
    wr(16'h03B5, 8'h55, "R8");
    rd(16'h03B5, "R4");
    step(1'b0, 1'b0, 16'h03B5, 8'h00, "R4");  // read data holds
    wr(16'h03B4, 8'h02, "R4");
    wr(16'h03B5, 8'hAA, "R5");
    rd(16'h03D5, "R3");
    rd(16'h03D4, "R3");
    wr(16'h03D4, 8'h05, "R3");
    wr(16'h03D5, 8'h33, "R3");
    rd(16'h03B4, "R3");
    wr(16'h03BA, 8'hFF, "R10");
    wr(16'h03DA, 8'h00, "R3");
    rd(16'h03C0, "R4");
    // switch to colour page
    wr(16'h03C2, 8'hFF, "R9");
    wr(16'h03D4, 8'h00, "R2");
    wr(16'h03D5, 8'h12, "R8");
    rd(16'h03B5, "R3");
    wr(16'h03B4, 8'h09, "R3");
    wr(16'h03DA, 8'hEF, "R10");
    wr(16'h03D4, 8'h07, "R2");
    wr(16'h03D5, 8'h2F, "R8");
    // engage protection
    wr(16'h03D4, 8'h11, "R6");
    wr(16'h03D5, 8'h80, "R8");
    wr(16'h03D4, 8'h03, "R6");
    wr(16'h03D5, 8'h77, "R6");
    wr(16'h03D4, 8'h00, "R6");
    wr(16'h03D5, 8'hFF, "R6");
    wr(16'h03D4, 8'h07, "R7");
    wr(16'h03D5, 8'hFF, "R7");
    wr(16'h03D5, 8'h00, "R7");
    wr(16'h03D4, 8'h08, "R6");
    wr(16'h03D5, 8'h44, "R6");
    wr(16'h03D4, 8'h17, "R8");
    wr(16'h03D5, 8'h3C, "R8");
    wr(16'h03D4, 8'h18, "R8");
    wr(16'h03D5, 8'h3C, "R8");
    // release protection
    wr(16'h03D4, 8'h11, "R5");
    wr(16'h03D5, 8'h00, "R8");
    wr(16'h03D4, 8'h03, "R5");
    wr(16'h03D5, 8'h77, "R5");
    wr(16'h03D4, 8'hFF, "R4");
    wr(16'h03D5, 8'h99, "R4");
    rd(16'h03D5, "R4");
    // read before write in the same cycle
    step(1'b1, 1'b1, 16'h03D5, 8'h5A, "R4");
    rd(16'h03D5, "R4");
    // back to mono page
    wr(16'h03C2, 8'h10, "R9");
    for (int i = 0; i < 32; i++) begin
      wr(16'h03B4, 8'(i), "R11");
      wr(16'h03B5, 8'(i * 7 + 3), "R11");
    end
    for (int i = 0; i < 32; i += 5) begin
      wr(16'h03B4, 8'(i), "R4");
      rd(16'h03B5, "R4");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule